// File: doc/BRIEF.md
# Idle/Unassigned Cell Filter

This block sits in the receive path of a cell interface. For each received cell it looks at the header and decides whether the cell is an idle or unassigned cell. Such a cell is dropped. Every other cell is forwarded to the receive buffer. The header fields arrive in parallel with a one-cycle valid strobe. One clock later the block gives a verdict strobe, which carries a drop flag for that cell.

The idle test works on an 8-bit key built from the header. The four flow-control bits sit in key bits 7..4, the three payload-type bits in bits 3..1, and the cell-loss-priority bit in bit 0. The key is compared with a programmed pattern, but only where the programmed mask has ones. A key match alone is not enough: the cell is also required to carry an all-zero path identifier and an all-zero channel identifier. The whole test can be switched off.

Two saturating statistics counters record the outcome of every cell. One counts forwarded cells and the other counts dropped cells. A synchronous clear input resets both counters.

Top module: `iucell_filter`

## Requirements
- R1: While `rst` is high at a clock edge, `cell_vld_o`, `cell_drop_o`, `pass_cnt_o` and `idle_cnt_o` become zero at that edge.
- R2: With `flt_en_i` high, a cell is dropped when its key {gfc[3:0], pti[2:0], clp} (bit 7 = gfc[3], bit 0 = clp) equals `flt_pattern_i` on every bit where `flt_mask_i` is 1, and `vpi_i` and `vci_i` are both zero.
- R3: A key bit whose mask bit is 0 does not affect the verdict; a mask of 0x00 makes every zero-identifier cell match.
- R4: A cell with any nonzero bit in `vpi_i` or `vci_i` is never dropped.
- R5: With `flt_en_i` low, no cell is dropped.
- R6: `cell_vld_o` is high in exactly the cycle after a cycle with `hdr_vld_i` high. `cell_drop_o` gives that cell's verdict and is low whenever `cell_vld_o` is low.
- R7: Each forwarded cell adds one to `pass_cnt_o` and each dropped cell adds one to `idle_cnt_o`. Both counters change in the same cycle in which `cell_vld_o` reports the cell.
- R8: A counter that holds all ones stays at all ones when further cells of its class arrive.
- R9: `cnt_clr_i` clears both counters at the next edge. A cell presented in the same cycle as the clear is counted after the clear, so its counter reads 1.
- R10: In a cycle without `hdr_vld_i` and without `cnt_clr_i`, both counters keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_vld_i | input | 1 | Header fields valid this cycle |
| gfc_i | input | 4 | Generic flow control bits |
| vpi_i | input | VPI_W | Virtual path identifier |
| vci_i | input | VCI_W | Virtual channel identifier |
| pti_i | input | 3 | Payload type bits |
| clp_i | input | 1 | Cell loss priority bit |
| flt_en_i | input | 1 | Filter enable |
| flt_pattern_i | input | 8 | Programmed key pattern |
| flt_mask_i | input | 8 | Compare mask, 1 = compare this bit |
| cnt_clr_i | input | 1 | Synchronous clear of both counters |
| cell_vld_o | output | 1 | Verdict valid |
| cell_drop_o | output | 1 | Cell is dropped |
| pass_cnt_o | output | CNT_W | Forwarded cell count, saturating |
| idle_cnt_o | output | CNT_W | Dropped cell count, saturating |

## Verification
Two events can fall in the same cycle: a counter clear and a counted cell. The bench provokes this by raising `cnt_clr_i` in the same cycle as the valid strobe of a dropped cell. It then requires the dropped-cell counter to read 1 and the forwarded-cell counter to read 0. A clear in a cycle with no cell must give 0 on both counters. Saturation coinciding with further cells is provoked on a narrow-counter instance. That instance receives more forwarded cells than its counter can hold, and its counter must stay at all ones.

// File: rtl/iuf_pkg.sv
package iuf_pkg;

    localparam int KEY_W = 8;

    // Compared header key: order fixes the bit positions (gfc high, clp low)
    typedef struct packed {
        logic [3:0] gfc;
        logic [2:0] pti;
        logic       clp;
    } iuf_key_t;

    typedef struct packed {
        logic             en;
        logic [KEY_W-1:0] pattern;
        logic [KEY_W-1:0] mask;
    } iuf_cfg_t;

    typedef struct packed {
        logic vld;
        logic drop;
    } iuf_verdict_t;

    typedef enum logic [1:0] {
        CELL_NONE = 2'b00,
        CELL_PASS = 2'b01,
        CELL_IDLE = 2'b10
    } iuf_class_e;

    // Masked compare: mask bit 1 means the bit takes part
    function automatic logic iuf_key_hit(input iuf_key_t key, input iuf_cfg_t cfg);
        logic [KEY_W-1:0] diff;
        diff = (KEY_W'(key) ^ cfg.pattern) & cfg.mask;
        return (diff == '0);
    endfunction

endpackage

// File: rtl/iuf_hdr_match.sv
module iuf_hdr_match
    import iuf_pkg::*;
#(
    parameter int VPI_W = 8,
    parameter int VCI_W = 16
) (
    input  iuf_key_t         key_i,
    input  logic [VPI_W-1:0] vpi_i,
    input  logic [VCI_W-1:0] vci_i,
    input  iuf_cfg_t         cfg_i,
    output logic             match_o
);

    logic ids_zero;
    logic key_hit;

    always_comb begin
        ids_zero = (vpi_i == '0) && (vci_i == '0);
        key_hit  = iuf_key_hit(key_i, cfg_i);
        match_o  = cfg_i.en && ids_zero && key_hit;
    end

endmodule

// File: rtl/iuf_sat_cnt.sv
module iuf_sat_cnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= inc_i ? CNT_ONE : '0;
        end else if (inc_i && (cnt_o != CNT_MAX)) begin
            cnt_o <= cnt_o + CNT_ONE;
        end
    end

endmodule

// File: rtl/iucell_filter.sv
module iucell_filter
    import iuf_pkg::*;
#(
    parameter int VPI_W = 8,
    parameter int VCI_W = 16,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_vld_i,
    input  logic [3:0]       gfc_i,
    input  logic [VPI_W-1:0] vpi_i,
    input  logic [VCI_W-1:0] vci_i,
    input  logic [2:0]       pti_i,
    input  logic             clp_i,
    input  logic             flt_en_i,
    input  logic [7:0]       flt_pattern_i,
    input  logic [7:0]       flt_mask_i,
    input  logic             cnt_clr_i,
    output logic             cell_vld_o,
    output logic             cell_drop_o,
    output logic [CNT_W-1:0] pass_cnt_o,
    output logic [CNT_W-1:0] idle_cnt_o
);

    localparam int NUM_CNT = 2;

    iuf_key_t     hdr_key;
    iuf_cfg_t     flt_cfg;
    logic         is_idle;
    iuf_class_e   cell_class;
    iuf_verdict_t verdict_q;
    logic [NUM_CNT-1:0]            cnt_inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;

    always_comb begin
        hdr_key.gfc     = gfc_i;
        hdr_key.pti     = pti_i;
        hdr_key.clp     = clp_i;
        flt_cfg.en      = flt_en_i;
        flt_cfg.pattern = flt_pattern_i;
        flt_cfg.mask    = flt_mask_i;
    end

    iuf_hdr_match #(
        .VPI_W(VPI_W),
        .VCI_W(VCI_W)
    ) u_match (
        .key_i  (hdr_key),
        .vpi_i  (vpi_i),
        .vci_i  (vci_i),
        .cfg_i  (flt_cfg),
        .match_o(is_idle)
    );

    always_comb begin
        if (!hdr_vld_i)   cell_class = CELL_NONE;
        else if (is_idle) cell_class = CELL_IDLE;
        else              cell_class = CELL_PASS;
        cnt_inc[0] = (cell_class == CELL_PASS);
        cnt_inc[1] = (cell_class == CELL_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q.vld  <= (cell_class != CELL_NONE);
            verdict_q.drop <= (cell_class == CELL_IDLE);
        end
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        iuf_sat_cnt #(
            .W(CNT_W)
        ) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .clr_i(cnt_clr_i),
            .inc_i(cnt_inc[i]),
            .cnt_o(cnt_val[i])
        );
    end

    assign cell_vld_o  = verdict_q.vld;
    assign cell_drop_o = verdict_q.drop;
    assign pass_cnt_o  = cnt_val[0];
    assign idle_cnt_o  = cnt_val[1];

endmodule

// File: rtl/iucell_filter_chk.sv
module iucell_filter_chk #(
    parameter int VPI_W = 8,
    parameter int VCI_W = 16,
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             hdr_vld_i,
    input logic [VPI_W-1:0] vpi_i,
    input logic [VCI_W-1:0] vci_i,
    input logic             flt_en_i,
    input logic             cnt_clr_i,
    input logic             cell_vld_o,
    input logic             cell_drop_o,
    input logic [CNT_W-1:0] pass_cnt_o,
    input logic [CNT_W-1:0] idle_cnt_o
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!cell_vld_o && !cell_drop_o && pass_cnt_o == '0 && idle_cnt_o == '0));

    p_ids_r4: assert property (@(posedge clk) disable iff (rst)
        (hdr_vld_i && (vpi_i != '0 || vci_i != '0)) |=> !cell_drop_o);

    p_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        (hdr_vld_i && !flt_en_i) |=> !cell_drop_o);

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        hdr_vld_i |=> cell_vld_o);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        !hdr_vld_i |=> !cell_vld_o);

    p_drop_qual_r6: assert property (@(posedge clk) disable iff (rst)
        !cell_vld_o |-> !cell_drop_o);

    p_pass_step_r7: assert property (@(posedge clk) disable iff (rst)
        (hdr_vld_i && !cnt_clr_i && pass_cnt_o != CMAX) |=>
            (cell_drop_o || pass_cnt_o == $past(pass_cnt_o) + 1'b1));

    p_idle_step_r7: assert property (@(posedge clk) disable iff (rst)
        (hdr_vld_i && !cnt_clr_i && idle_cnt_o != CMAX) |=>
            (!cell_drop_o || idle_cnt_o == $past(idle_cnt_o) + 1'b1));

    p_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (pass_cnt_o == CMAX && !cnt_clr_i) |=> pass_cnt_o == CMAX);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_clr_i && !hdr_vld_i) |=> (pass_cnt_o == '0 && idle_cnt_o == '0));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!hdr_vld_i && !cnt_clr_i) |=> ($stable(pass_cnt_o) && $stable(idle_cnt_o)));

endmodule

bind iucell_filter iucell_filter_chk #(
    .VPI_W(VPI_W),
    .VCI_W(VCI_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hdr_vld_i  (hdr_vld_i),
    .vpi_i      (vpi_i),
    .vci_i      (vci_i),
    .flt_en_i   (flt_en_i),
    .cnt_clr_i  (cnt_clr_i),
    .cell_vld_o (cell_vld_o),
    .cell_drop_o(cell_drop_o),
    .pass_cnt_o (pass_cnt_o),
    .idle_cnt_o (idle_cnt_o)
);

// File: tb/iucell_filter_test.sv
module iucell_filter_test;

    localparam int VPI_W = 8;
    localparam int VCI_W = 16;
    localparam int CNT_W = 24;
    localparam int SAT_W = 3;
    localparam int NVEC  = 11;

    // vector: en(1) pattern(8) mask(8) key(8) vpi(8) vci(16) expected_drop(1)
    localparam logic [49:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 8'hFF, 8'h00, 8'h00, 16'h0000, 1'b1}, // R2 exact idle
        {1'b1, 8'h00, 8'hFF, 8'h01, 8'h00, 16'h0000, 1'b0}, // R2 clp mismatch
        {1'b1, 8'h01, 8'hFF, 8'h01, 8'h00, 16'h0000, 1'b1}, // R2 pattern with clp
        {1'b1, 8'h00, 8'hFE, 8'h01, 8'h00, 16'h0000, 1'b1}, // R3 clp ignored
        {1'b1, 8'h00, 8'h0F, 8'hF0, 8'h00, 16'h0000, 1'b1}, // R3 gfc ignored
        {1'b1, 8'h00, 8'hF0, 8'hF0, 8'h00, 16'h0000, 1'b0}, // R2 gfc compared
        {1'b1, 8'h00, 8'hFF, 8'h00, 8'h01, 16'h0000, 1'b0}, // R4 vpi nonzero
        {1'b1, 8'h00, 8'hFF, 8'h00, 8'h00, 16'h8000, 1'b0}, // R4 vci nonzero
        {1'b0, 8'h00, 8'hFF, 8'h00, 8'h00, 16'h0000, 1'b0}, // R5 disabled
        {1'b1, 8'hA5, 8'h00, 8'h3C, 8'h00, 16'h0000, 1'b1}, // R3 mask all zero
        {1'b1, 8'h0E, 8'h0E, 8'h0E, 8'h00, 16'h0000, 1'b1}  // R2 pti bits 3..1
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             hdr_vld_i = 1'b0;
    logic             sat_vld = 1'b0;
    logic [3:0]       gfc_i = '0;
    logic [VPI_W-1:0] vpi_i = '0;
    logic [VCI_W-1:0] vci_i = '0;
    logic [2:0]       pti_i = '0;
    logic             clp_i = 1'b0;
    logic             flt_en_i = 1'b0;
    logic [7:0]       flt_pattern_i = '0;
    logic [7:0]       flt_mask_i = '0;
    logic             cnt_clr_i = 1'b0;
    logic             cell_vld_o, cell_drop_o;
    logic [CNT_W-1:0] pass_cnt_o, idle_cnt_o;
    logic             s_vld, s_drop;
    logic [SAT_W-1:0] s_pass, s_idle;

    int errors = 0;
    int checks = 0;
    int exp_pass = 0;
    int exp_idle = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    iucell_filter #(.VPI_W(VPI_W), .VCI_W(VCI_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .hdr_vld_i(hdr_vld_i), .gfc_i(gfc_i), .vpi_i(vpi_i),
        .vci_i(vci_i), .pti_i(pti_i), .clp_i(clp_i), .flt_en_i(flt_en_i),
        .flt_pattern_i(flt_pattern_i), .flt_mask_i(flt_mask_i), .cnt_clr_i(cnt_clr_i),
        .cell_vld_o(cell_vld_o), .cell_drop_o(cell_drop_o),
        .pass_cnt_o(pass_cnt_o), .idle_cnt_o(idle_cnt_o)
    );

    iucell_filter #(.VPI_W(VPI_W), .VCI_W(VCI_W), .CNT_W(SAT_W)) uut_sat (
        .clk(clk), .rst(rst), .hdr_vld_i(sat_vld), .gfc_i(gfc_i), .vpi_i(vpi_i),
        .vci_i(vci_i), .pti_i(pti_i), .clp_i(clp_i), .flt_en_i(flt_en_i),
        .flt_pattern_i(flt_pattern_i), .flt_mask_i(flt_mask_i), .cnt_clr_i(cnt_clr_i),
        .cell_vld_o(s_vld), .cell_drop_o(s_drop),
        .pass_cnt_o(s_pass), .idle_cnt_o(s_idle)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 vld", 32'(cell_vld_o), 0);
        chk("R1 drop", 32'(cell_drop_o), 0);
        chk("R1 pass", pass_cnt_o, 0);
        chk("R1 idle", idle_cnt_o, 0);
        rst = 1'b0;
        @(negedge clk);

        // Vector walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            flt_en_i      = VEC[i][49];
            flt_pattern_i = VEC[i][48:41];
            flt_mask_i    = VEC[i][40:33];
            {gfc_i, pti_i, clp_i} = VEC[i][32:25];
            vpi_i         = VEC[i][24:17];
            vci_i         = VEC[i][16:1];
            hdr_vld_i     = 1'b1;
            @(negedge clk);
            hdr_vld_i = 1'b0;
            if (VEC[i][0]) exp_idle++; else exp_pass++;
            chk($sformatf("R6 vld vec%0d", i), 32'(cell_vld_o), 1);
            chk($sformatf("R2 drop vec%0d", i), 32'(cell_drop_o), 32'(VEC[i][0]));
            chk($sformatf("R7 pass vec%0d", i), pass_cnt_o, exp_pass);
            chk($sformatf("R7 idle vec%0d", i), idle_cnt_o, exp_idle);
        end

        // R6 no verdict without a cell; R10 counters hold
        @(negedge clk);
        chk("R6 vld idle cycle", 32'(cell_vld_o), 0);
        chk("R6 drop idle cycle", 32'(cell_drop_o), 0);
        chk("R10 pass hold", pass_cnt_o, exp_pass);
        chk("R10 idle hold", idle_cnt_o, exp_idle);

        // R9 clear together with a dropped cell
        flt_en_i = 1'b1; flt_pattern_i = 8'h00; flt_mask_i = 8'hFF;
        {gfc_i, pti_i, clp_i} = 8'h00; vpi_i = '0; vci_i = '0;
        hdr_vld_i = 1'b1; cnt_clr_i = 1'b1;
        @(negedge clk);
        hdr_vld_i = 1'b0; cnt_clr_i = 1'b0;
        chk("R9 idle after clear+cell", idle_cnt_o, 1);
        chk("R9 pass after clear+cell", pass_cnt_o, 0);
        chk("R9 drop flag", 32'(cell_drop_o), 1);

        // R9 clear alone
        cnt_clr_i = 1'b1;
        @(negedge clk);
        cnt_clr_i = 1'b0;
        chk("R9 idle cleared", idle_cnt_o, 0);
        chk("R9 pass cleared", pass_cnt_o, 0);

        // R8 saturation on narrow counter: 9 forwarded cells into 3 bits
        vpi_i = 8'h05;
        sat_vld = 1'b1;
        repeat (9) @(negedge clk);
        sat_vld = 1'b0;
        chk("R8 pass saturated", 32'(s_pass), 7);
        chk("R8 idle untouched", 32'(s_idle), 0);
        @(negedge clk);
        chk("R8 pass stays", 32'(s_pass), 7);

        // R1 reset mid-run clears counters
        rst = 1'b1;
        @(negedge clk);
        chk("R1 sat pass after reset", 32'(s_pass), 0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule